// File: doc/BRIEF.md
# Destination Address Hash Filter

This block makes the accept-or-reject decision for a received Ethernet frame from its 48-bit destination address. The address arrives one byte per valid cycle, and a start marker flags the first byte. While the bytes come in, the block builds the address and runs a CRC-32 over it. When the last address byte arrives, it compares the address with the station's own address and checks for broadcast. It also looks up a hash index in a 64-bit filter table through a one-hot decode followed by an OR reduction.

A hash hit is gated by the group bit of the address. A hit on an individual address (group bit clear) needs one enable, and a hit on a group address (group bit set) needs another. Broadcast acceptance, exact-match acceptance and a promiscuous catch-all each have their own enable. The registered decision carries a match-type code that the receive status logic downstream can report. The block does no error checking and no buffering of the frame.

Top module: `daf_filter`

## Requirements
- R1: After a synchronous reset, and until the first decision, `dec_valid`, `dec_accept` and `dec_reject` are 0 and `dec_kind` is 0 (none).
- R2: `dec_valid` goes to 1 on the clock edge that takes the sixth address byte, so it is seen one cycle after that byte. The decision is held unchanged until a byte with `da_sof` set arrives, and that edge clears it. Enables, own address and table are sampled on the sixth-byte edge only.
- R3: Byte k of the frame (k = 0 first) is compared with `own_addr[8k+7:8k]`. A full match with `en_exact` set gives accept with kind 1.
- R4: The hash index is bits 31..26 of a CRC-32 register (polynomial 04C11DB7h, preset to all ones, no final inversion). The register is fed with the six address bytes in order, each byte least significant bit first. The lookup hits when `hash_table[index]` is 1.
- R5: A hash hit on an address whose bit 0 of byte 0 is 0 is accepted with kind 2, and only when `en_hash_ind` is set.
- R6: A hash hit on an address whose bit 0 of byte 0 is 1 is accepted with kind 3, and only when `en_mcast` is set. The all-ones address never takes this path.
- R7: The all-ones address with `en_bcast` set is accepted with kind 4.
- R8: With `en_promisc` set, a frame that no other path accepts is accepted with kind 5.
- R9: When several paths apply, the kind follows the priority exact (1), broadcast (4), hashed individual (2), multicast (3), promiscuous (5). A frame that no path accepts gives `dec_reject` = 1 and kind 0, and `dec_accept` is always the inverse of `dec_reject` while `dec_valid` is 1.
- R10: Bytes with `da_valid` set before any start marker, and bytes after the sixth, have no effect on the outputs. Idle cycles with `da_valid` low between address bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_valid | input | 1 | Address byte present this cycle |
| da_sof | input | 1 | Marks the first address byte of a frame |
| da_byte | input | 8 | Address byte |
| own_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| hash_table | input | 64 | Hash filter table, one bit per index |
| en_exact | input | 1 | Enable exact station-address match |
| en_hash_ind | input | 1 | Enable hash acceptance of individual addresses |
| en_mcast | input | 1 | Enable hash acceptance of group addresses |
| en_bcast | input | 1 | Enable broadcast acceptance |
| en_promisc | input | 1 | Accept every frame |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame rejected |
| dec_kind | output | 3 | 0 none, 1 exact, 2 hashed individual, 3 multicast, 4 broadcast, 5 promiscuous |

## Verification
The assertions assume that the enables are stable in the cycle of the sixth byte. They also assume that a new start marker always opens a new frame, so a frame never has fewer than six bytes before its decision. The bench changes the controls only when no frame is in progress, and it always sends a start marker before a frame. The one exception is a deliberate run of stray bytes after reset, which tests that bytes without a start are ignored. Hash hits are forced by filling the table from an index the bench computes itself. Misses use an empty table, so no vector can hit by accident through an index collision.

// File: rtl/daf_pkg.sv
package daf_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_EXACT = 3'd1,
    K_HIND  = 3'd2,
    K_MCAST = 3'd3,
    K_BCAST = 3'd4,
    K_PROM  = 3'd5
  } kind_e;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // Advance a CRC-32 register by one byte, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_capture.sv
module daf_capture #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic [7:0]            in_byte,
  output logic [8*NBYTES-1:0]   addr_cur,
  output logic [HASH_W-1:0]     hash_idx,
  output logic                  last_byte
);
  localparam int AW = 8 * NBYTES;
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(NBYTES);
  localparam logic [CW-1:0] CNT_LAST = CW'(NBYTES - 1);

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   crc_q;
  logic [31:0]   crc_cur;
  logic [CW-1:0] slot;
  logic          take;

  always_comb begin
    slot      = in_sof ? '0 : cnt_q;
    take      = in_valid && (in_sof || (cnt_q < CNT_DONE));
    last_byte = take && (slot == CNT_LAST);
    addr_cur  = in_sof ? '0 : addr_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (slot == CW'(b)) addr_cur[8*b +: 8] = in_byte;
    end
    crc_cur  = daf_pkg::crc_step_byte(in_sof ? 32'hFFFF_FFFF : crc_q, in_byte);
    hash_idx = crc_cur[31 -: HASH_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_DONE;
      addr_q <= '0;
      crc_q  <= 32'hFFFF_FFFF;
    end else if (take) begin
      cnt_q  <= slot + CW'(1);
      addr_q <= addr_cur;
      crc_q  <= crc_cur;
    end
  end

  // R10
  no_extra_byte_chk: assert property (@(posedge clk) disable iff (rst)
    last_byte |=> (!last_byte || in_sof));

endmodule

// File: rtl/daf_hash_lookup.sv
module daf_hash_lookup #(
  parameter int HASH_W = 6
) (
  input  logic [HASH_W-1:0]       idx,
  input  logic [(1<<HASH_W)-1:0]  table_bits,
  output logic                    hit
);
  localparam int TN = 1 << HASH_W;

  logic [TN-1:0] line;
  logic [TN-1:0] masked;

  for (genvar g = 0; g < TN; g++) begin : g_line
    assign line[g]   = (idx == HASH_W'(g));
    assign masked[g] = line[g] & table_bits[g];
  end

  assign hit = |masked;

endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int AW = 48
) (
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   own,
  input  logic            hash_hit,
  input  logic            en_exact,
  input  logic            en_hash_ind,
  input  logic            en_mcast,
  input  logic            en_bcast,
  input  logic            en_promisc,
  output daf_pkg::kind_e  kind
);
  logic is_bcast, is_group, is_own;

  always_comb begin
    is_bcast = &addr;
    is_group = addr[0];
    is_own   = (addr == own);
    if (en_exact && is_own)                              kind = daf_pkg::K_EXACT;
    else if (en_bcast && is_bcast)                       kind = daf_pkg::K_BCAST;
    else if (en_hash_ind && hash_hit && !is_group)       kind = daf_pkg::K_HIND;
    else if (en_mcast && hash_hit && is_group && !is_bcast) kind = daf_pkg::K_MCAST;
    else if (en_promisc)                                 kind = daf_pkg::K_PROM;
    else                                                 kind = daf_pkg::K_NONE;
  end

endmodule

// File: rtl/daf_filter.sv
module daf_filter #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6,
  localparam int AW = 8 * NBYTES,
  localparam int TN = 1 << HASH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          da_valid,
  input  logic          da_sof,
  input  logic [7:0]    da_byte,
  input  logic [AW-1:0] own_addr,
  input  logic [TN-1:0] hash_table,
  input  logic          en_exact,
  input  logic          en_hash_ind,
  input  logic          en_mcast,
  input  logic          en_bcast,
  input  logic          en_promisc,
  output logic          dec_valid,
  output logic          dec_accept,
  output logic          dec_reject,
  output logic [2:0]    dec_kind
);
  logic [AW-1:0]     cap_addr;
  logic [HASH_W-1:0] cap_idx;
  logic              cap_last;
  logic              hash_hit;
  daf_pkg::kind_e    kind_c;

  daf_capture #(.NBYTES(NBYTES), .HASH_W(HASH_W)) u_capture (
    .clk(clk), .rst(rst), .in_valid(da_valid), .in_sof(da_sof),
    .in_byte(da_byte), .addr_cur(cap_addr), .hash_idx(cap_idx),
    .last_byte(cap_last)
  );

  daf_hash_lookup #(.HASH_W(HASH_W)) u_lookup (
    .idx(cap_idx), .table_bits(hash_table), .hit(hash_hit)
  );

  daf_decide #(.AW(AW)) u_decide (
    .addr(cap_addr), .own(own_addr), .hash_hit(hash_hit),
    .en_exact(en_exact), .en_hash_ind(en_hash_ind), .en_mcast(en_mcast),
    .en_bcast(en_bcast), .en_promisc(en_promisc), .kind(kind_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reject <= 1'b0;
      dec_kind   <= daf_pkg::K_NONE;
    end else if (cap_last) begin
      dec_valid  <= 1'b1;
      dec_accept <= (kind_c != daf_pkg::K_NONE);
      dec_reject <= (kind_c == daf_pkg::K_NONE);
      dec_kind   <= kind_c;
    end else if (da_valid && da_sof) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reject <= 1'b0;
      dec_kind   <= daf_pkg::K_NONE;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_valid && !dec_accept && !dec_reject));

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_valid) |-> $past(cap_last));

  // R2
  hold_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(dec_valid) && !$past(cap_last)) |-> $stable(dec_kind));

  // R9
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_accept != dec_reject));

  // R6
  mcast_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dec_valid) && dec_kind == daf_pkg::K_MCAST) |-> $past(en_mcast));

  // R8
  promisc_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dec_valid) && dec_kind == daf_pkg::K_PROM) |-> $past(en_promisc));

endmodule

// File: tb/daf_filter_tb.sv
`timescale 1ns/1ps
module daf_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        da_valid = 1'b0, da_sof = 1'b0;
  logic [7:0]  da_byte = 8'h00;
  logic [47:0] own_addr;
  logic [63:0] hash_table = '0;
  logic        en_exact = 0, en_hash_ind = 0, en_mcast = 0, en_bcast = 0, en_promisc = 0;
  logic        dec_valid, dec_accept, dec_reject;
  logic [2:0]  dec_kind;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  daf_filter u_dut (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da_sof(da_sof), .da_byte(da_byte),
    .own_addr(own_addr), .hash_table(hash_table),
    .en_exact(en_exact), .en_hash_ind(en_hash_ind), .en_mcast(en_mcast),
    .en_bcast(en_bcast), .en_promisc(en_promisc),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject),
    .dec_kind(dec_kind)
  );

  localparam logic [47:0] OWN = 48'h6655_4433_2202;
  localparam logic [47:0] AU  = 48'hEEDD_CCBB_AA10;
  localparam logic [47:0] AM  = 48'h0A0B_0C0D_0E01;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] U2  = 48'h1234_5678_9A00;

  // {table_on, address, enables {prom,bcast,mcast,hind,exact}, expected kind}
  localparam int NV = 15;
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, OWN, 5'b00001, 3'd1},
    {1'b0, OWN, 5'b00000, 3'd0},
    {1'b0, U2,  5'b00001, 3'd0},
    {1'b1, AU,  5'b00010, 3'd2},
    {1'b1, AU,  5'b00100, 3'd0},
    {1'b1, AM,  5'b00100, 3'd3},
    {1'b1, AM,  5'b00010, 3'd0},
    {1'b0, BC,  5'b01000, 3'd4},
    {1'b0, BC,  5'b00100, 3'd0},
    {1'b0, U2,  5'b10000, 3'd5},
    {1'b0, BC,  5'b11111, 3'd4},
    {1'b0, OWN, 5'b11111, 3'd1},
    {1'b1, AU,  5'b10110, 3'd2},
    {1'b1, AM,  5'b10100, 3'd3},
    {1'b0, AM,  5'b00100, 3'd0}
  };

  // Reflected-form CRC; index bit 5 is the first reflected bit.
  function automatic int idx_of(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (r[0] ^ a[k]) r = (r >> 1) ^ 32'hEDB8_8320;
      else             r = r >> 1;
    end
    return {26'd0, r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_dec(input string tag, input int kind);
    check(dec_valid == 1'b1, tag, dec_valid, 1);
    check(dec_kind == 3'(kind), tag, dec_kind, kind);
    check(dec_accept == (kind != 0) && dec_reject == (kind == 0), tag,
          {dec_accept, dec_reject}, (kind != 0) ? 2 : 1);
  endtask

  // Sends six bytes, with `gap` idle cycles between bytes; returns at the
  // negedge after the sixth byte's posedge.
  task automatic send_frame(input logic [47:0] a, input int gap);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      da_valid = 1'b1; da_sof = (b == 0); da_byte = a[8*b +: 8];
      if (b == 5) begin
        check(dec_valid == 1'b0, "R2 cleared before sixth byte", dec_valid, 0);
      end
      if (gap > 0 && b < 5) begin
        @(negedge clk);
        da_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0;
  endtask

  task automatic set_en(input logic [4:0] e);
    {en_promisc, en_bcast, en_mcast, en_hash_ind, en_exact} = e;
  endtask

  logic [63:0] full_tbl;

  initial begin
    own_addr = OWN;
    full_tbl = '0;
    full_tbl[idx_of(AU)] = 1'b1;
    full_tbl[idx_of(AM)] = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(!dec_valid && !dec_accept && !dec_reject && dec_kind == 3'd0,
          "R1 reset state", {dec_valid, dec_accept, dec_reject, dec_kind}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R10: bytes with no start marker are ignored
    set_en(5'b11111);
    for (int b = 0; b < 6; b++) begin
      da_valid = 1'b1; da_sof = 1'b0; da_byte = OWN[8*b +: 8];
      @(negedge clk);
    end
    da_valid = 1'b0;
    @(negedge clk);
    check(dec_valid == 1'b0, "R10 no start marker", dec_valid, 0);
    check(dec_kind == 3'd0, "R10 no start marker kind", dec_kind, 0);

    // Vector table: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      hash_table = VEC[v][56] ? full_tbl : '0;
      set_en(VEC[v][7:3]);
      send_frame(VEC[v][55:8], 0);
      check_dec($sformatf("R9 vector %0d", v), int'(VEC[v][2:0]));
    end

    // R2: held while controls change, cleared by the next start marker
    hash_table = '0; set_en(5'b00001);
    send_frame(OWN, 0);
    set_en(5'b00000);
    repeat (4) @(negedge clk);
    check_dec("R2 hold", 1);
    da_valid = 1'b1; da_sof = 1'b1; da_byte = U2[7:0];
    @(negedge clk);
    da_valid = 1'b0; da_sof = 1'b0;
    check(dec_valid == 1'b0, "R2 start clears", dec_valid, 0);

    // R10: trailing bytes after the sixth are ignored
    set_en(5'b00001);
    send_frame(OWN, 0);
    da_valid = 1'b1; da_byte = 8'h77;
    repeat (3) @(negedge clk);
    da_valid = 1'b0;
    @(negedge clk);
    check_dec("R10 trailing bytes", 1);

    // R4: idle gaps between bytes do not disturb the hash
    hash_table = full_tbl; set_en(5'b00100);
    send_frame(AM, 2);
    check_dec("R4 gapped frame", 3);

    // R6: broadcast with a hashed hit is not multicast
    hash_table = '0; hash_table[idx_of(BC)] = 1'b1;
    set_en(5'b00110);
    send_frame(BC, 0);
    check_dec("R6 broadcast not multicast", 0);

    // R8: promiscuous accepts a broadcast when broadcast is disabled
    set_en(5'b10000);
    send_frame(BC, 1);
    check_dec("R8 promisc broadcast", 5);

    // R1: reset mid-hold clears the decision
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(dec_valid == 1'b0 && dec_kind == 3'd0, "R1 reset after decision",
          {dec_valid, dec_kind}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule